// File: doc/BRIEF.md
# Embedded DRAM Page Controller

This controller drives one on-chip DRAM block that runs on a memory clock at half the core rate. Every command it issues (open a page, move one 256-bit word, close a page) takes exactly one memory clock. The controller runs on that memory clock. The block is split into half-blocks. Each half-block holds two sub-arrays, and these are interleaved page by page: the lowest bit of a page number picks the sub-array, and the remaining page bits pick the row inside it. A sub-array together with its half-block is called a bank below.

A client presents one word request at a time through a valid/ready handshake. The controller keeps the open row of every bank. A request that hits the open row goes straight to the transfer. A request to a closed bank is activated first. A request to a bank with a different open row is precharged first, then activated. A programmable period counter raises refresh requests. A refresh walks round-robin over every page of the block, and for each page it closes the bank if needed, activates the page and precharges it. A due refresh waits for a request sequence already in progress to finish. While the refresh is pending, the controller refuses new requests.

Top module: `edram_page_ctrl`

## Requirements
- R1: A request address is split, from the least significant end, into a word index (`COL_W` bits), a sub-array select (1 bit), a row (`ROW_W` bits) and a half-block index. The bank driven on `dram_bank` is {half-block, sub-array select}. The transfer command carries the request's row on `dram_row` and its word index on `dram_col`.
- R2: A word written to an address is returned unchanged by a later read of the same address.
- R3: If the bank already holds the requested row open, the transfer command (`dram_cmd` 2 = read, 3 = write) is issued in the first cycle after acceptance, with no activate.
- R4: If the bank is closed, the controller issues an activate (`dram_cmd` 1) in the first cycle after acceptance and the transfer in the second.
- R5: If the bank holds a different row open, the controller issues a precharge (`dram_cmd` 4), then an activate, then the transfer, in three consecutive cycles. An activate is never issued to a bank that is open, and a precharge is never issued to a bank that is closed.
- R6: `rsp_valid` is high, carrying the read word on `rsp_rdata`, in exactly the cycle after each read command and in no other cycle.
- R7: With a non-zero `refresh_period` P and no request traffic, refresh sequences start exactly P cycles apart. A period of 0 produces no refresh.
- R8: Refreshes visit pages in ascending page order, where the page number is the request address without its word index, and wrap after the last page. Each refresh closes its bank (precharging first if the bank was open), activates the page and precharges it.
- R9: A refresh never splits a request sequence: every command between acceptance and the transfer belongs to that request's bank. While a refresh is pending or running, `req_ready` is low.
- R10: After reset `req_ready` is high, `dram_cmd` is 0 (no operation), `rsp_valid` is low and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_period | input | CNT_W | Cycles between refreshes, 0 disables refresh |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address {half-block, row, sub-array, word} |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | Read word valid |
| rsp_rdata | output | DATA_W | Read word |
| dram_cmd | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| dram_bank | output | BANK_W | Target bank {half-block, sub-array} |
| dram_row | output | ROW_W | Row for activate and transfer |
| dram_col | output | COL_W | Word within the page |
| dram_wdata | output | DATA_W | Word to write |
| dram_rdata | input | DATA_W | Array read word, valid the cycle after a read |

## Verification
Two functions can meet in the same cycle: the refresh period can expire in the very cycle a request is accepted, or while that request is part-way through its precharge/activate/transfer sequence. The bench provokes this by streaming pseudo-random requests, many of them page conflicts, against a short refresh period, so refresh expiry lands at every offset of the request sequences. For each request the bench judges that every command up to the transfer targets that request's bank and that the latency matches what its own open-page model predicts. It also judges that each refresh command appears only while `req_ready` is low, and that refresh addresses keep their round-robin order.

// File: rtl/edram_pkg.sv
package edram_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_XFER,
    ST_RPRE,
    ST_RACT,
    ST_RCLOSE
  } seq_state_e;

endpackage

// File: rtl/edram_page_track.sv
module edram_page_track #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 9,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_open,
  input  logic              upd_close,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic [BANK_W-1:0] qa_bank,
  output logic              qa_open,
  output logic [ROW_W-1:0]  qa_row,
  input  logic [BANK_W-1:0] qb_bank,
  output logic              qb_open
);

  logic [NBANK-1:0] open_vec;
  logic [ROW_W-1:0] row_arr [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic             open_q, open_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic             sel;

    assign sel = (upd_bank == BANK_W'(g));

    always_comb begin
      open_d = open_q;
      row_d  = row_q;
      if (sel && upd_open) begin
        open_d = 1'b1;
        row_d  = upd_row;
      end else if (sel && upd_close) begin
        open_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else begin
        open_q <= open_d;
        row_q  <= row_d;
      end
    end

    assign open_vec[g] = open_q;
    assign row_arr[g]  = row_q;
  end

  assign qa_open = open_vec[qa_bank];
  assign qa_row  = row_arr[qa_bank];
  assign qb_open = open_vec[qb_bank];

endmodule

// File: rtl/edram_refresh_sched.sv
module edram_refresh_sched #(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period,
  input  logic              done,
  output logic              pend,
  output logic [PAGE_W-1:0] page
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              enabled, expire;

  assign enabled = (period != '0);
  assign expire  = enabled && (cnt_q >= (period - 1'b1));

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    page_d = page_q;
    if (expire)       cnt_d = '0;
    else if (enabled) cnt_d = cnt_q + 1'b1;
    if (expire)       pend_d = 1'b1;
    else if (done)    pend_d = 1'b0;
    if (done)         page_d = page_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      page_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      page_q <= page_d;
    end
  end

  assign pend = pend_q;
  assign page = page_q;

endmodule

// File: rtl/edram_cmd_seq.sv
module edram_cmd_seq
  import edram_pkg::*;
#(
  parameter int NHB    = 2,
  parameter int ROW_W  = 9,
  parameter int COL_W  = 3,
  parameter int DATA_W = 256,
  localparam int HB_W   = $clog2(NHB),
  localparam int BANK_W = HB_W + 1,
  localparam int PAGE_W = HB_W + ROW_W + 1,
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              rf_pend,
  input  logic [PAGE_W-1:0] rf_page,
  output logic              rf_done,
  output logic [BANK_W-1:0] look_req_bank,
  input  logic              look_req_open,
  input  logic [ROW_W-1:0]  look_req_row,
  output logic [BANK_W-1:0] look_rf_bank,
  input  logic              look_rf_open,
  output logic              trk_open,
  output logic              trk_close,
  output logic [BANK_W-1:0] trk_bank,
  output logic [ROW_W-1:0]  trk_row,
  output logic [2:0]        dram_cmd,
  output logic [BANK_W-1:0] dram_bank,
  output logic [ROW_W-1:0]  dram_row,
  output logic [COL_W-1:0]  dram_col,
  output logic [DATA_W-1:0] dram_wdata,
  output logic              rsp_valid
);

  // request address fields
  logic [COL_W-1:0] in_col;
  logic             in_sa;
  logic [ROW_W-1:0] in_row;
  logic [HB_W-1:0]  in_hb;
  assign in_col = req_addr[COL_W-1:0];
  assign in_sa  = req_addr[COL_W];
  assign in_row = req_addr[COL_W+ROW_W:COL_W+1];
  assign in_hb  = req_addr[ADDR_W-1:COL_W+ROW_W+1];

  // refresh page fields (same layout without the word index)
  logic             rf_sa;
  logic [ROW_W-1:0] rf_row;
  logic [HB_W-1:0]  rf_hb;
  assign rf_sa  = rf_page[0];
  assign rf_row = rf_page[ROW_W:1];
  assign rf_hb  = rf_page[PAGE_W-1:ROW_W+1];

  assign look_req_bank = {in_hb, in_sa};
  assign look_rf_bank  = {rf_hb, rf_sa};

  seq_state_e        state_q, state_d;
  logic [BANK_W-1:0] cur_bank_q;
  logic [ROW_W-1:0]  cur_row_q;
  logic [COL_W-1:0]  cur_col_q;
  logic              cur_wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_q, rsp_d;
  logic              accept;
  dram_cmd_e         cmd;

  assign req_ready = (state_q == ST_IDLE) && !rf_pend;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rf_pend)
          state_d = look_rf_open ? ST_RPRE : ST_RACT;
        else if (req_valid) begin
          if (!look_req_open)               state_d = ST_ACT;
          else if (look_req_row == in_row)  state_d = ST_XFER;
          else                              state_d = ST_PRE;
        end
      end
      ST_PRE:    state_d = ST_ACT;
      ST_ACT:    state_d = ST_XFER;
      ST_XFER:   state_d = ST_IDLE;
      ST_RPRE:   state_d = ST_RACT;
      ST_RACT:   state_d = ST_RCLOSE;
      ST_RCLOSE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bank_q <= '0;
      cur_row_q  <= '0;
      cur_col_q  <= '0;
      cur_wr_q   <= 1'b0;
      wdata_q    <= '0;
    end else if (accept) begin
      cur_bank_q <= {in_hb, in_sa};
      cur_row_q  <= in_row;
      cur_col_q  <= in_col;
      cur_wr_q   <= req_write;
      wdata_q    <= req_wdata;
    end
  end

  always_comb begin
    cmd       = CMD_NOP;
    dram_bank = cur_bank_q;
    dram_row  = cur_row_q;
    unique case (state_q)
      ST_PRE:    cmd = CMD_PRE;
      ST_ACT:    cmd = CMD_ACT;
      ST_XFER:   cmd = cur_wr_q ? CMD_WR : CMD_RD;
      ST_RPRE: begin
        cmd       = CMD_PRE;
        dram_bank = {rf_hb, rf_sa};
        dram_row  = rf_row;
      end
      ST_RACT: begin
        cmd       = CMD_ACT;
        dram_bank = {rf_hb, rf_sa};
        dram_row  = rf_row;
      end
      ST_RCLOSE: begin
        cmd       = CMD_PRE;
        dram_bank = {rf_hb, rf_sa};
        dram_row  = rf_row;
      end
      default:   cmd = CMD_NOP;
    endcase
  end

  assign dram_cmd   = cmd;
  assign dram_col   = cur_col_q;
  assign dram_wdata = wdata_q;

  assign trk_open  = (cmd == CMD_ACT);
  assign trk_close = (cmd == CMD_PRE);
  assign trk_bank  = dram_bank;
  assign trk_row   = dram_row;

  assign rf_done = (state_q == ST_RCLOSE);

  assign rsp_d = (state_q == ST_XFER) && !cur_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= rsp_d;
  end

  assign rsp_valid = rsp_q;

endmodule

// File: rtl/edram_page_ctrl.sv
module edram_page_ctrl #(
  parameter int NHB    = 2,
  parameter int ROW_W  = 9,
  parameter int COL_W  = 3,
  parameter int DATA_W = 256,
  parameter int CNT_W  = 16,
  localparam int HB_W   = $clog2(NHB),
  localparam int BANK_W = HB_W + 1,
  localparam int NBANK  = NHB * 2,
  localparam int PAGE_W = HB_W + ROW_W + 1,
  localparam int ADDR_W = PAGE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  refresh_period,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [2:0]        dram_cmd,
  output logic [BANK_W-1:0] dram_bank,
  output logic [ROW_W-1:0]  dram_row,
  output logic [COL_W-1:0]  dram_col,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata
);

  logic              rf_pend, rf_done;
  logic [PAGE_W-1:0] rf_page;
  logic [BANK_W-1:0] look_req_bank, look_rf_bank, trk_bank;
  logic              look_req_open, look_rf_open, trk_open, trk_close;
  logic [ROW_W-1:0]  look_req_row, trk_row;

  edram_refresh_sched #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .period(refresh_period), .done(rf_done),
    .pend(rf_pend), .page(rf_page)
  );

  edram_page_track #(.NBANK(NBANK), .ROW_W(ROW_W)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .upd_open(trk_open), .upd_close(trk_close), .upd_bank(trk_bank), .upd_row(trk_row),
    .qa_bank(look_req_bank), .qa_open(look_req_open), .qa_row(look_req_row),
    .qb_bank(look_rf_bank), .qb_open(look_rf_open)
  );

  edram_cmd_seq #(.NHB(NHB), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rf_pend(rf_pend), .rf_page(rf_page), .rf_done(rf_done),
    .look_req_bank(look_req_bank), .look_req_open(look_req_open), .look_req_row(look_req_row),
    .look_rf_bank(look_rf_bank), .look_rf_open(look_rf_open),
    .trk_open(trk_open), .trk_close(trk_close), .trk_bank(trk_bank), .trk_row(trk_row),
    .dram_cmd(dram_cmd), .dram_bank(dram_bank), .dram_row(dram_row),
    .dram_col(dram_col), .dram_wdata(dram_wdata), .rsp_valid(rsp_valid)
  );

  assign rsp_rdata = dram_rdata;

endmodule

// File: rtl/edram_page_ctrl_chk.sv
module edram_page_ctrl_chk
  import edram_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rf_pend,
  input logic [2:0]        dram_cmd,
  input logic [BANK_W-1:0] dram_bank
);

  // R6: read data follows each read command by one cycle
  a_r6_rsp_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cmd == CMD_RD) |=> rsp_valid);

  // R6: no response without a read one cycle earlier
  a_r6_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(dram_cmd) == CMD_RD));

  // R3: an activate is followed by a transfer or a closing precharge on the same bank
  a_r3_act_then_use: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cmd == CMD_ACT) |=>
      ((dram_cmd == CMD_RD || dram_cmd == CMD_WR || dram_cmd == CMD_PRE) && $stable(dram_bank)));

  // R5: a precharge is followed by an activate or by idling
  a_r5_pre_then_act: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cmd == CMD_PRE) |=> (dram_cmd == CMD_ACT || dram_cmd == CMD_NOP));

  // R9: an accepted request starts its command sequence at once
  a_r9_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (dram_cmd != CMD_NOP && !req_ready));

  // R7: a due refresh on an idle controller starts in the next cycle
  a_r7_refresh_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_pend && dram_cmd == CMD_NOP) |=> (dram_cmd == CMD_ACT || dram_cmd == CMD_PRE));

endmodule

bind edram_page_ctrl edram_page_ctrl_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rf_pend(rf_pend), .dram_cmd(dram_cmd), .dram_bank(dram_bank)
);

// File: tb/edram_page_ctrl_bench.sv
module edram_page_ctrl_bench;

  localparam int NHB = 2, ROW_W = 2, COL_W = 3, DATA_W = 32, CNT_W = 8;
  localparam int BANK_W = 2, NBANK = 4, PAGE_W = 4, ADDR_W = 7;
  localparam int NWORD = 1 << ADDR_W;
  localparam int NPAGE = 1 << PAGE_W;

  logic              clk, rst_n;
  logic [CNT_W-1:0]  refresh_period;
  logic              req_valid, req_write, req_ready, rsp_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_rdata, dram_wdata, dram_rdata;
  logic [2:0]        dram_cmd;
  logic [BANK_W-1:0] dram_bank;
  logic [ROW_W-1:0]  dram_row;
  logic [COL_W-1:0]  dram_col;

  edram_page_ctrl #(.NHB(NHB), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CNT_W(CNT_W))
  u_edram_page_ctrl (
    .clk(clk), .rst_n(rst_n), .refresh_period(refresh_period),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_cmd(dram_cmd), .dram_bank(dram_bank), .dram_row(dram_row), .dram_col(dram_col),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural array with protocol checking
  logic [DATA_W-1:0] arr [NWORD];
  bit               m_open [NBANK];
  logic [ROW_W-1:0] m_row  [NBANK];
  initial begin
    for (int i = 0; i < NWORD; i++) arr[i] = '0;
    for (int b = 0; b < NBANK; b++) begin m_open[b] = 0; m_row[b] = '0; end
    dram_rdata = '0;
  end

  function automatic int widx(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r,
                              input logic [COL_W-1:0] c);
    return int'({b[BANK_W-1:1], r, b[0], c});
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      case (dram_cmd)
        3'd1: begin
          check(!m_open[dram_bank], "R5", "activate to open bank", 1, 0);
          m_open[dram_bank] = 1; m_row[dram_bank] = dram_row;
        end
        3'd4: begin
          check(m_open[dram_bank], "R5", "precharge to closed bank", 0, 1);
          m_open[dram_bank] = 0;
        end
        3'd2: begin
          check(m_open[dram_bank] && m_row[dram_bank] == dram_row, "R1", "read outside open row",
                dram_row, m_row[dram_bank]);
          dram_rdata <= arr[widx(dram_bank, dram_row, dram_col)];
        end
        3'd3: begin
          check(m_open[dram_bank] && m_row[dram_bank] == dram_row, "R1", "write outside open row",
                dram_row, m_row[dram_bank]);
          arr[widx(dram_bank, dram_row, dram_col)] = dram_wdata;
        end
        default: ;
      endcase
    end
  end

  // bench model of expected open pages and refresh order
  bit               e_open [NBANK];
  logic [ROW_W-1:0] e_row  [NBANK];
  logic [DATA_W-1:0] e_mem [NWORD];
  bit  req_busy = 0;
  bit  spacing_on = 0;
  int  rf_acts = 0;
  int  rf_ptr = 0;
  int  last_start = -1;
  logic [2:0] prev_cmd = 3'd0;

  always @(negedge clk) begin
    if (rst_n && !req_busy && dram_cmd != 3'd0 && dram_cmd != 3'd2 && dram_cmd != 3'd3) begin
      check(req_ready == 1'b0, "R9", "ready during refresh", req_ready, 0);
      if (prev_cmd == 3'd0) begin
        if (spacing_on && last_start >= 0)
          check(cyc - last_start == int'(refresh_period), "R7", "refresh spacing",
                cyc - last_start, refresh_period);
        last_start = cyc;
      end
      if (dram_cmd == 3'd1) begin
        check(dram_bank == BANK_W'({rf_ptr[PAGE_W-1], rf_ptr[0]}) &&
              dram_row == ROW_W'(rf_ptr >> 1), "R8", "refresh page",
              {dram_bank, dram_row}, rf_ptr);
        e_open[dram_bank] = 0;
        rf_ptr = (rf_ptr + 1) % NPAGE;
        rf_acts++;
      end
    end
    prev_cmd = dram_cmd;
  end

  task automatic do_req(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [BANK_W-1:0] b;
    logic [ROW_W-1:0]  r;
    int exp_lat, lat, guard;
    string tag;
    b = {a[ADDR_W-1], a[COL_W]};
    r = a[COL_W+ROW_W:COL_W+1];
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    if (!e_open[b])        begin exp_lat = 2; tag = "R4"; end
    else if (e_row[b] == r) begin exp_lat = 1; tag = "R3"; end
    else                   begin exp_lat = 3; tag = "R5"; end
    e_open[b] = 1; e_row[b] = r;
    req_busy = 1;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (dram_cmd != 3'd2 && dram_cmd != 3'd3 && lat < 8) begin
      check(dram_bank == b, "R9", "foreign command inside request", dram_bank, b);
      lat++;
      @(negedge clk);
    end
    check(lat == exp_lat, tag, "transfer latency", lat, exp_lat);
    check(dram_bank == b && dram_row == r && dram_col == a[COL_W-1:0], "R1", "transfer address",
          {dram_bank, dram_row, dram_col}, {b, r, a[COL_W-1:0]});
    check(dram_cmd == (wr ? 3'd3 : 3'd2), "R1", "transfer kind", dram_cmd, wr ? 3 : 2);
    req_busy = 0;
    if (wr) e_mem[a] = d;
    else begin
      @(negedge clk);
      check(rsp_valid == 1'b1, "R6", "response valid", rsp_valid, 1);
      check(rsp_rdata == e_mem[a], "R2", "read data", rsp_rdata, e_mem[a]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 60000 && !finished) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 60000);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lf;
    int a0, c0;
    for (int b = 0; b < NBANK; b++) begin e_open[b] = 0; e_row[b] = '0; end
    for (int i = 0; i < NWORD; i++) e_mem[i] = '0;
    rst_n = 0; refresh_period = '0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    check(dram_cmd == 3'd0, "R10", "command after reset", dram_cmd, 0);
    check(rsp_valid == 1'b0, "R10", "response after reset", rsp_valid, 0);

    // refresh disabled: nothing happens
    repeat (60) @(negedge clk);
    check(rf_acts == 0, "R7", "refreshes with period 0", rf_acts, 0);

    // full write sweep, then permuted read sweep
    for (int i = 0; i < NWORD; i++)
      do_req(1, ADDR_W'(i), DATA_W'(32'hC3A50000 ^ (i * 32'h01030507)));
    for (int i = 0; i < NWORD; i++)
      do_req(0, ADDR_W'((i * 37) % NWORD), '0);

    // idle refresh cadence and order
    refresh_period = 8'd16;
    spacing_on = 1;
    repeat (16 * 12) @(negedge clk);
    check(rf_acts >= 10, "R7", "idle refresh count", rf_acts, 10);
    spacing_on = 0;

    // mixed traffic colliding with a short refresh period
    refresh_period = 8'd11;
    a0 = rf_acts; c0 = cyc;
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_req(lf[8], lf[6:0], {lf, ~lf});
    end
    check(rf_acts - a0 >= (cyc - c0) / 11 - 2, "R9", "refreshes under load",
          rf_acts - a0, (cyc - c0) / 11 - 2);

    // final readback after refresh activity
    refresh_period = '0;
    for (int i = 0; i < NWORD; i += 5) do_req(0, ADDR_W'(i), '0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule